// File: doc/BRIEF.md
# Serial Key-Event Relay Node

This block is one link in a chain of relay nodes that carry key events toward a central controller. Every node in the chain runs on the same bit clock. Each node shifts in a serial stream from the node upstream of it and cuts that stream into bytes by counting clock cycles modulo 8. It picks two-byte event records out of the stream and sends them on toward the controller. An event record is a type byte whose most significant bit is set, followed by a hop-count byte. The node adds one to the hop count of every record it forwards, so the count that reaches the controller is the number of nodes the record went through.

A node can also start a record of its own. A request presents a type byte and a count byte. The node latches them and splices the pair into its outgoing stream. The splice happens only at a record boundary, so a local record never lands between a forwarded type byte and its count byte. Outgoing bytes wait in a small queue, and a byte starts on the output line only at the start of a byte slot. When the node has nothing to send, the output line stays low.

Top module: `relay_node`

## Requirements
- R1: A byte is made of 8 bits sampled on rising clock edges, most significant bit first. Slot 0 starts at the first edge after reset, and each later slot starts 8 edges after the one before it.
- R2: When the node expects a type byte, a received byte with bit 7 = 1 is forwarded unchanged and the node then expects a count byte. A received byte with bit 7 = 0 is dropped, and the node keeps expecting a type byte.
- R3: The byte that follows an accepted type byte is forwarded as its value plus one, modulo 256 (0xFF becomes 0x00). The node then expects a type byte again.
- R4: The output line carries bytes only in whole slots that line up with the input slots, most significant bit first. A byte received in slot s goes out no earlier than slot s+2. The output line matches a cycle-accurate model of the queue on every clock.
- R5: A local request is latched when no local record is pending. The latched type byte and count byte go out as two adjacent bytes. They enter the output queue only while the parser expects a type byte, so a local record never splits a forwarded record. loc_pending stays high until the count byte has been queued.
- R6: A request that arrives while a local record is pending is ignored.
- R7: ser_out is 0 in every slot in which no byte is being sent.
- R8: A synchronous reset clears the slot counter, the parser (which then expects a type byte), the output queue and the pending local record. ser_out and loc_pending read 0 while reset is held.
- R9: No forwarded byte is ever lost. The queue keeps one entry free for forwarded traffic, so back-to-back records mixed with local requests all arrive intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared bit clock |
| rst | input | 1 | Synchronous reset, active high |
| ser_in | input | 1 | Serial data from the upstream node |
| ser_out | output | 1 | Serial data toward the controller |
| loc_req | input | 1 | Strobe for a local event record |
| loc_type | input | 8 | Type byte of the local record |
| loc_count | input | 8 | Count byte of the local record |
| loc_pending | output | 1 | A latched local record has not yet been fully queued |

## Verification
The assertions assume that every upstream node keeps the same slot phase as this one. Under that assumption a forwarded byte can reach the queue only once per slot, on the first cycle of the slot. The stimulus holds to this by driving ser_in one whole byte at a time, starting on the first edge after reset. The assertions do not assume that the upstream stream is well formed. The bench deliberately sends an unmarked byte where a type byte is expected, and it sends local requests while a forwarded record is half received. It also sends a second request while a record is still pending, which tests the rule that such requests are ignored.

// File: rtl/relay_pkg.sv
package relay_pkg;
  localparam int BYTE_W = 8;

  typedef logic [BYTE_W-1:0] byte_t;

  // Marker bit: a type byte carries a 1 in its top bit.
  function automatic logic is_marker(input byte_t b);
    return b[BYTE_W-1];
  endfunction

  // Hop count arithmetic: plus one, wrapping at the byte width.
  function automatic byte_t bump_hop(input byte_t b);
    return b + byte_t'(1);
  endfunction
endpackage

// File: rtl/relay_framer.sv
module relay_framer
  import relay_pkg::*;
#(
  parameter int BW = BYTE_W,
  localparam int CW = $clog2(BW)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ser_in,
  output logic [CW-1:0] slot_cnt,
  output logic          slot_end,
  output logic          rx_valid,
  output logic [BW-1:0] rx_byte
);
  logic [BW-1:0] shift_q;

  assign slot_end = (slot_cnt == CW'(BW-1));

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_cnt <= '0;
      shift_q  <= '0;
      rx_valid <= 1'b0;
      rx_byte  <= '0;
    end else begin
      shift_q  <= {shift_q[BW-2:0], ser_in};
      rx_valid <= slot_end;
      if (slot_end) begin
        rx_byte  <= {shift_q[BW-2:0], ser_in};
        slot_cnt <= '0;
      end else begin
        slot_cnt <= slot_cnt + CW'(1);
      end
    end
  end
endmodule

// File: rtl/relay_parser.sv
module relay_parser
  import relay_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  rx_valid,
  input  byte_t rx_byte,
  output logic  fwd_push,
  output byte_t fwd_byte,
  output logic  expect_type
);
  logic want_count_q;

  assign expect_type = !want_count_q;

  always_comb begin
    fwd_push = 1'b0;
    fwd_byte = rx_byte;
    if (rx_valid) begin
      if (want_count_q) begin
        fwd_push = 1'b1;
        fwd_byte = bump_hop(rx_byte);
      end else begin
        fwd_push = is_marker(rx_byte);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      want_count_q <= 1'b0;
    end else if (rx_valid) begin
      if (want_count_q)
        want_count_q <= 1'b0;
      else if (is_marker(rx_byte))
        want_count_q <= 1'b1;
    end
  end
endmodule

// File: rtl/relay_fifo.sv
module relay_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [W-1:0]  push_data,
  input  logic          pop,
  output logic [W-1:0]  head,
  output logic [LW-1:0] level,
  output logic          full,
  output logic          empty
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          do_push, do_pop;

  assign full    = (level == LW'(DEPTH));
  assign empty   = (level == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head    = mem[rd_ptr];

  function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
    return (p == AW'(DEPTH-1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (do_push) wr_ptr <= ptr_next(wr_ptr);
      if (do_pop)  rd_ptr <= ptr_next(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   level <= level + LW'(1);
        2'b01:   level <= level - LW'(1);
        default: level <= level;
      endcase
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (do_push && wr_ptr == AW'(i)) mem[i] <= push_data;
    end
  end
endmodule

// File: rtl/relay_tx.sv
module relay_tx #(
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          slot_end,
  input  logic          have_data,
  input  logic [BW-1:0] data,
  output logic          tx_load,
  output logic          tx_active,
  output logic          ser_out
);
  logic [BW-1:0] sh_q;

  assign tx_load = slot_end && have_data;
  assign ser_out = tx_active && sh_q[BW-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q      <= '0;
      tx_active <= 1'b0;
    end else if (slot_end) begin
      tx_active <= have_data;
      sh_q      <= have_data ? data : '0;
    end else begin
      sh_q <= {sh_q[BW-2:0], 1'b0};
    end
  end
endmodule

// File: rtl/relay_node.sv
module relay_node
  import relay_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int BW = BYTE_W,
  localparam int CW = $clog2(BW),
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        ser_in,
  output logic        ser_out,
  input  logic        loc_req,
  input  logic [7:0]  loc_type,
  input  logic [7:0]  loc_count,
  output logic        loc_pending
);
  // Named internal events, visible to the bound checker.
  logic [CW-1:0] slot_cnt;
  logic          slot_end, rx_valid, fwd_push, expect_type;
  byte_t         rx_byte, fwd_byte, q_head, push_data;
  logic          q_full, q_empty, push, tx_load, tx_active;
  logic [LW-1:0] q_level;
  logic          loc_push_type, loc_push_cnt, stage_q;
  byte_t         lt_q, lc_q;
  logic          window_ok, room_ok;

  relay_framer #(.BW(BW)) u_framer (
    .clk(clk), .rst(rst), .ser_in(ser_in), .slot_cnt(slot_cnt),
    .slot_end(slot_end), .rx_valid(rx_valid), .rx_byte(rx_byte)
  );

  relay_parser u_parser (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .fwd_push(fwd_push), .fwd_byte(fwd_byte), .expect_type(expect_type)
  );

  // A local pair starts only when both bytes fit before the next
  // forwarded slot and one entry stays free for forwarded traffic.
  assign window_ok = (slot_cnt >= CW'(1)) && (slot_cnt <= CW'(BW-3));
  assign room_ok   = (int'(q_level) <= DEPTH-3);
  assign loc_push_type = loc_pending && !stage_q && !rx_valid &&
                         window_ok && room_ok && expect_type;
  assign loc_push_cnt  = stage_q;

  assign push      = fwd_push || loc_push_type || loc_push_cnt;
  assign push_data = fwd_push ? fwd_byte : (loc_push_cnt ? lc_q : lt_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      loc_pending <= 1'b0;
      stage_q     <= 1'b0;
      lt_q        <= '0;
      lc_q        <= '0;
    end else begin
      if (loc_push_cnt) begin
        loc_pending <= 1'b0;
        stage_q     <= 1'b0;
      end else if (loc_push_type) begin
        stage_q <= 1'b1;
      end
      if (!loc_pending && loc_req) begin
        loc_pending <= 1'b1;
        lt_q        <= loc_type;
        lc_q        <= loc_count;
      end
    end
  end

  relay_fifo #(.W(BW), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .push(push), .push_data(push_data),
    .pop(tx_load), .head(q_head), .level(q_level),
    .full(q_full), .empty(q_empty)
  );

  relay_tx #(.BW(BW)) u_tx (
    .clk(clk), .rst(rst), .slot_end(slot_end), .have_data(!q_empty),
    .data(q_head), .tx_load(tx_load), .tx_active(tx_active),
    .ser_out(ser_out)
  );
endmodule

// File: rtl/relay_node_chk.sv
module relay_node_chk #(
  parameter int CW = 3
) (
  input logic          clk,
  input logic          rst,
  input logic [CW-1:0] slot_cnt,
  input logic          rx_valid,
  input logic          fwd_push,
  input logic          q_full,
  input logic          tx_load,
  input logic          loc_push_type,
  input logic          loc_push_cnt,
  input logic          expect_type,
  input logic          loc_pending,
  input logic          ser_out
);
  a_r9_no_overflow: assert property (@(posedge clk) disable iff (rst)
    fwd_push |-> !q_full);

  a_r4_load_on_boundary: assert property (@(posedge clk) disable iff (rst)
    tx_load |=> (slot_cnt == '0));

  a_r1_rx_slot_start: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> (slot_cnt == '0));

  a_r5_pair_adjacent: assert property (@(posedge clk) disable iff (rst)
    loc_push_type |=> loc_push_cnt);

  a_r5_no_splice: assert property (@(posedge clk) disable iff (rst)
    loc_push_type |-> expect_type);

  a_r6_pending_held: assert property (@(posedge clk) disable iff (rst)
    (loc_pending && !loc_push_cnt) |=> loc_pending);

  a_r8_reset_quiet: assert property (@(posedge clk)
    rst |=> (!ser_out && !loc_pending));
endmodule

bind relay_node relay_node_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst(rst), .slot_cnt(slot_cnt), .rx_valid(rx_valid),
  .fwd_push(fwd_push), .q_full(q_full), .tx_load(tx_load),
  .loc_push_type(loc_push_type), .loc_push_cnt(loc_push_cnt),
  .expect_type(expect_type), .loc_pending(loc_pending), .ser_out(ser_out)
);

// File: tb/relay_node_test.sv
`timescale 1ns/1ps
module relay_node_test;
  localparam int DEPTH = 4;
  logic clk = 1'b0, rst = 1'b1, ser_in = 1'b0, loc_req = 1'b0;
  logic [7:0] loc_type = '0, loc_count = '0;
  logic ser_out, loc_pending;
  int checks = 0, failures = 0, cycles = 0;

  relay_node #(.DEPTH(DEPTH)) uut (
    .clk(clk), .rst(rst), .ser_in(ser_in), .ser_out(ser_out),
    .loc_req(loc_req), .loc_type(loc_type), .loc_count(loc_count),
    .loc_pending(loc_pending)
  );

  always #2.5 clk = ~clk;

  // Behavioural reference model
  logic [7:0] m_sh, m_rxb, m_tx, m_lt, m_lc, o_rxb, acc;
  logic m_rxv, m_act, m_exp_cnt, m_pend, m_stage, o_pend, o_rxv, o_exp;
  int m_cnt, oc, sz0;
  logic [7:0] q[$];
  logic [7:0] log_b[$];

  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      m_sh = 0; m_rxb = 0; m_tx = 0; m_rxv = 0; m_act = 0; m_exp_cnt = 0;
      m_pend = 0; m_stage = 0; m_cnt = 0; q.delete();
    end else begin
      sz0 = q.size(); o_pend = m_pend; oc = m_cnt;
      o_rxv = m_rxv; o_rxb = m_rxb; o_exp = m_exp_cnt;
      if (oc == 7) begin
        if (q.size() > 0) begin m_tx = q.pop_front(); m_act = 1; end
        else m_act = 0;
      end else m_tx = {m_tx[6:0], 1'b0};
      if (o_rxv) begin
        if (o_exp) begin
          if (sz0 < DEPTH) q.push_back(o_rxb + 8'd1);
          m_exp_cnt = 0;
        end else if (o_rxb[7]) begin
          if (sz0 < DEPTH) q.push_back(o_rxb);
          m_exp_cnt = 1;
        end
      end else if (m_stage) begin
        q.push_back(m_lc); m_stage = 0; m_pend = 0;
      end else if (m_pend && oc >= 1 && oc <= 5 && sz0 <= DEPTH-3 && !o_exp) begin
        q.push_back(m_lt); m_stage = 1;
      end
      if (!o_pend && loc_req) begin m_pend = 1; m_lt = loc_type; m_lc = loc_count; end
      m_sh = {m_sh[6:0], ser_in};
      m_rxv = (oc == 7);
      if (oc == 7) m_rxb = m_sh;
      m_cnt = (oc + 1) % 8;
    end
  end

  // Per-cycle comparison and output byte log
  always @(negedge clk) begin
    if (!rst) begin
      checks++;
      if (ser_out !== (m_act & m_tx[7])) begin
        failures++;
        $display("FAIL R4 ser_out actual %0b expected %0b at cycle %0d", ser_out, m_act & m_tx[7], cycles);
      end
      checks++;
      if (loc_pending !== m_pend) begin
        failures++;
        $display("FAIL R5 loc_pending actual %0b expected %0b at cycle %0d", loc_pending, m_pend, cycles);
      end
      acc = {acc[6:0], ser_out};
      if (m_cnt == 7) log_b.push_back(acc);
    end
  end

  initial begin
    #(5.0 * 150000);
    failures++;
    $display("FAIL watchdog actual hung expected done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  task automatic check(input string req, input logic got, input logic exp, input string what);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s %s actual %0b expected %0b", req, what, got, exp);
    end
  endtask

  function automatic logic has_pair(input logic [7:0] a, input logic [7:0] b);
    for (int i = 0; i + 1 < log_b.size(); i++)
      if (log_b[i] == a && log_b[i+1] == b) return 1'b1;
    return 1'b0;
  endfunction

  function automatic logic has_byte(input logic [7:0] a);
    foreach (log_b[i]) if (log_b[i] == a) return 1'b1;
    return 1'b0;
  endfunction

  // Send one byte MSB first; optional requests at given bit indices.
  task automatic send_byte(input logic [7:0] b, input int r1 = -1,
                           input logic [7:0] t1 = 0, input logic [7:0] c1 = 0,
                           input int r2 = -1, input logic [7:0] t2 = 0,
                           input logic [7:0] c2 = 0);
    for (int i = 0; i < 8; i++) begin
      ser_in = b[7-i];
      loc_req = 1'b0;
      if (i == r1) begin loc_req = 1'b1; loc_type = t1; loc_count = c1; end
      if (i == r2) begin loc_req = 1'b1; loc_type = t2; loc_count = c2; end
      @(negedge clk);
    end
    loc_req = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) send_byte(8'h00);
  endtask

  task automatic do_reset();
    rst = 1'b1; ser_in = 1'b0; loc_req = 1'b0;
    repeat (3) @(negedge clk);
    check("R8", ser_out, 1'b0, "ser_out in reset");
    check("R8", loc_pending, 1'b0, "loc_pending in reset");
    rst = 1'b0;
  endtask

  initial begin
    logic ok;
    @(negedge clk);
    do_reset();
    // R1 R2 R3: forwarded record gains one hop
    send_byte(8'h80); send_byte(8'h01); idle(3);
    check("R1", has_pair(8'h80, 8'h02), 1'b1, "R3 record 80/01 relayed as 80/02");
    // R2: unmarked byte dropped, parser still expects type
    send_byte(8'h35); send_byte(8'hA0); send_byte(8'h05); idle(3);
    check("R2", has_pair(8'hA0, 8'h06), 1'b1, "record after dropped byte");
    check("R2", has_byte(8'h35) | has_byte(8'h36), 1'b0, "unmarked byte forwarded");
    // R3: wrap of count
    send_byte(8'h81); send_byte(8'hFF); idle(3);
    check("R3", has_pair(8'h81, 8'h00), 1'b1, "count FF wraps to 00");
    // R5: local record alone
    send_byte(8'h00, 0, 8'hC4, 8'h01); idle(3);
    check("R5", has_pair(8'hC4, 8'h01), 1'b1, "local record sent");
    // R5: request while a forwarded record is half received
    send_byte(8'h90); send_byte(8'h07, 1, 8'hC8, 8'h01); idle(4);
    check("R5", has_pair(8'h90, 8'h08), 1'b1, "forwarded record intact");
    check("R5", has_pair(8'hC8, 8'h01), 1'b1, "local record after boundary");
    // R6: second request while pending is ignored
    send_byte(8'h00, 0, 8'hD0, 8'h01, 1, 8'hE0, 8'h02); idle(3);
    check("R6", has_pair(8'hD0, 8'h01), 1'b1, "first request kept");
    check("R6", has_byte(8'hE0), 1'b0, "second request ignored");
    // R9: back-to-back records mixed with local requests
    for (int k = 0; k < 6; k++) begin
      send_byte(8'h82 + 8'(k), 2, 8'hF0 + 8'(k), 8'h01);
      send_byte(8'h10 + 8'(k), 3, 8'hF0 + 8'(k), 8'h01);
    end
    idle(10);
    ok = 1'b1;
    for (int k = 0; k < 6; k++) ok &= has_pair(8'h82 + 8'(k), 8'h11 + 8'(k));
    check("R9", ok, 1'b1, "all stress records relayed");
    // R7: idle output is low for a whole slot
    idle(2);
    ok = 1'b0;
    for (int i = 0; i < 8; i++) begin ok |= ser_out; @(negedge clk); end
    check("R7", ok, 1'b0, "idle slot output");
    // R8: mid-run reset with a request pending
    send_byte(8'h80, 6, 8'hC1, 8'h01);
    do_reset();
    idle(2);
    check("R8", loc_pending, 1'b0, "pending cleared by reset");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule